// File: doc/BRIEF.md
# Amplifier Channel Overcurrent Fault Manager

This block supervises one output channel of an audio power stage against hard overcurrent events. A comparator outside the block raises a flag when the peak output current passes the shutdown threshold. When that flag is seen while the channel is playing, the block puts the output into high impedance, latches a readable fault bit and pulls an active-low fault pin. The channel then stays shut down until the host writes a self-clearing clear command.

What the clear does depends on a diagnostic-enable control bit. With diagnostics enabled, the block issues a load-diagnostic request and waits for the result. A pass returns the channel to play. A fail starts a retry loop: the block waits a programmable number of one-second ticks and then asks for the diagnostic again. The output stays in high impedance through every retry, so the stage is never driven hard into a short. With diagnostics disabled, the channel waits in high impedance, and a second clear returns it to play once the overcurrent flag has gone low. A further control bit picks one of two shutdown threshold levels for the sensing circuit.

Top module: `ocp_fault_mgr`

## Requirements
- R1: When `oc_trip` is high at a rising clock edge while the channel plays, `out_hiz` is high from that edge on.
- R2: The same trip sets the latched fault bit (bit 0 of the status register at address 0x10) and drives `fault_n` low.
- R3: Once shut down, the channel keeps `out_hiz` high and the fault bit set until a write of 1 to bit 7 of the command register at address 0x21. That clear command has no effect while the channel plays.
- R4: A clear issued with diagnostics enabled (bit 0 of the configuration register at address 0x01) produces exactly one `diag_req` pulse. A `diag_done` with `diag_pass` high returns the channel to play, with `out_hiz` low and `fault_n` high.
- R5: A `diag_done` with `diag_pass` low keeps `out_hiz` high. After `RETRY_TICKS` pulses of `tick_1s` the block issues a new request, and it issues none before that.
- R6: A clear issued with diagnostics disabled leaves the channel in high impedance with no request. A later clear returns it to play only if `oc_trip` is low at that time; otherwise the channel stays in high impedance.
- R7: Bit 4 of the configuration register drives `ilim_sel`. Only bits 4 and 0 of that register are stored, and the rest read as 0.
- R8: The clear command bit reads back as 0 one cycle after it is written.
- R9: An `oc_trip` that arrives during a diagnostic, a retry wait or the disabled-diagnostic hold is ignored. The fault bit stays 0 and no extra request is issued.
- R10: After reset the channel plays: `out_hiz` is 0, `fault_n` is 1, `ilim_sel` is 0, and the configuration and status registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| oc_trip | input | 1 | Overcurrent shutdown comparator flag |
| tick_1s | input | 1 | One-cycle pulse once per second |
| diag_req | output | 1 | One-cycle load-diagnostic request |
| diag_done | input | 1 | One-cycle diagnostic completion pulse |
| diag_pass | input | 1 | Diagnostic result, valid with `diag_done` (1 means no load fault) |
| out_hiz | output | 1 | Channel output forced to high impedance |
| fault_n | output | 1 | Active-low fault pin |
| ilim_sel | output | 1 | Shutdown threshold level select |

## Verification
The hardest state to reach is a second request from the retry loop. It needs a trip, a clear with diagnostics on, a failing result, and then an exact count of tick pulses. The stimulus counts each `diag_req` pulse at the clock edge and sends the ticks one at a time. It checks that the count has not moved after one tick fewer than the interval, and that it moves by one right after the last tick. Trips injected during the diagnostic wait and during the disabled-diagnostic hold are checked through the status register and the request count.

// File: rtl/ocf_pkg.sv
package ocf_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 8'h01;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 8'h10;
  localparam logic [ADDR_W-1:0] ADDR_CMD  = 8'h21;

  localparam int BIT_DIAG_EN = 0;
  localparam int BIT_LVL     = 4;
  localparam int BIT_CLR     = 7;

  typedef enum logic [2:0] {
    ST_PLAY  = 3'd0,
    ST_SHUT  = 3'd1,
    ST_DREQ  = 3'd2,
    ST_DWAIT = 3'd3,
    ST_RETRY = 3'd4,
    ST_HOLD  = 3'd5
  } ch_state_t;

  function automatic logic is_hiz(ch_state_t s);
    return s != ST_PLAY;
  endfunction

  function automatic logic [DATA_W-1:0] cfg_mask(logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] m;
    m = '0;
    m[BIT_DIAG_EN] = 1'b1;
    m[BIT_LVL]     = 1'b1;
    return d & m;
  endfunction
endpackage

// File: rtl/ocf_regs.sv
module ocf_regs
  import ocf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              trip_evt,
  output logic              clr_evt,
  output logic              diag_en,
  output logic              lvl_sel,
  output logic              fault_lat
);
  logic [DATA_W-1:0] cfg_q;
  logic              clr_q;
  logic              lat_q;
  logic              unused_wdata;

  assign unused_wdata = ^{wdata[6:5], wdata[3:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      clr_q <= 1'b0;
    end else begin
      clr_q <= wr && (addr == ADDR_CMD) && wdata[BIT_CLR];
      if (wr && addr == ADDR_CFG) cfg_q <= cfg_mask(wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lat_q <= 1'b0;
    else if (trip_evt) lat_q <= 1'b1;
    else if (clr_q)    lat_q <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_CFG:  rdata = cfg_q;
      ADDR_STAT: rdata[0] = lat_q;
      ADDR_CMD:  rdata[BIT_CLR] = clr_q;
      default:   rdata = '0;
    endcase
  end

  assign clr_evt   = clr_q;
  assign diag_en   = cfg_q[BIT_DIAG_EN];
  assign lvl_sel   = cfg_q[BIT_LVL];
  assign fault_lat = lat_q;
endmodule

// File: rtl/ocf_retry_timer.sv
module ocf_retry_timer #(
  parameter int RETRY_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int CNT_W = (RETRY_TICKS > 1) ? $clog2(RETRY_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RETRY_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || expire) cnt_q <= '0;
    else if (tick)           cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && tick && (cnt_q == LAST);
endmodule

// File: rtl/ocf_chan_fsm.sv
module ocf_chan_fsm
  import ocf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      oc_trip,
  input  logic      clr_evt,
  input  logic      diag_en,
  input  logic      diag_done,
  input  logic      diag_pass,
  input  logic      retry_expire,
  output ch_state_t state,
  output logic      trip_evt,
  output logic      pass_evt,
  output logic      fail_evt
);
  ch_state_t nxt;

  assign trip_evt = (state == ST_PLAY) && oc_trip;
  assign pass_evt = (state == ST_DWAIT) && diag_done && diag_pass;
  assign fail_evt = (state == ST_DWAIT) && diag_done && !diag_pass;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_PLAY:  if (trip_evt) nxt = ST_SHUT;
      ST_SHUT:  if (clr_evt)  nxt = diag_en ? ST_DREQ : ST_HOLD;
      ST_DREQ:  nxt = ST_DWAIT;
      ST_DWAIT: begin
        if (pass_evt)      nxt = ST_PLAY;
        else if (fail_evt) nxt = ST_RETRY;
      end
      ST_RETRY: if (retry_expire) nxt = ST_DREQ;
      ST_HOLD:  if (clr_evt && !oc_trip) nxt = ST_PLAY;
      default:  nxt = ST_SHUT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_PLAY;
    else        state <= nxt;
  end
endmodule

// File: rtl/ocp_fault_mgr.sv
module ocp_fault_mgr
  import ocf_pkg::*;
#(
  parameter int RETRY_TICKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              oc_trip,
  input  logic              tick_1s,
  output logic              diag_req,
  input  logic              diag_done,
  input  logic              diag_pass,
  output logic              out_hiz,
  output logic              fault_n,
  output logic              ilim_sel
);
  ch_state_t state;
  logic trip_evt, pass_evt, fail_evt, clr_evt;
  logic diag_en, fault_lat, retry_expire;

  ocf_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .trip_evt(trip_evt),
    .clr_evt(clr_evt), .diag_en(diag_en), .lvl_sel(ilim_sel),
    .fault_lat(fault_lat)
  );

  ocf_chan_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .oc_trip(oc_trip), .clr_evt(clr_evt),
    .diag_en(diag_en), .diag_done(diag_done), .diag_pass(diag_pass),
    .retry_expire(retry_expire), .state(state), .trip_evt(trip_evt),
    .pass_evt(pass_evt), .fail_evt(fail_evt)
  );

  ocf_retry_timer #(.RETRY_TICKS(RETRY_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state == ST_RETRY),
    .tick(tick_1s), .expire(retry_expire)
  );

  assign diag_req = (state == ST_DREQ);
  assign out_hiz  = is_hiz(state);
  assign fault_n  = !is_hiz(state);
endmodule

// File: rtl/ocp_fault_mgr_chk.sv
module ocp_fault_mgr_chk (
  input logic clk,
  input logic rst_n,
  input logic reg_wr,
  input logic oc_trip,
  input logic diag_req,
  input logic out_hiz,
  input logic fault_n,
  input logic ilim_sel,
  input logic trip_evt,
  input logic clr_evt,
  input logic pass_evt,
  input logic fail_evt,
  input logic fault_lat
);
  a_r1_trip_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    trip_evt |=> out_hiz);

  a_r2_trip_latch: assert property (@(posedge clk) disable iff (!rst_n)
    trip_evt |=> (fault_lat && !fault_n));

  a_r3_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (out_hiz && !clr_evt && !pass_evt) |=> out_hiz);

  a_r4_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> $past(clr_evt || pass_evt));

  a_r5_req_in_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    diag_req |-> out_hiz);

  a_r5_fail_stays_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> (out_hiz && !diag_req));

  a_r7_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(ilim_sel));

  a_r8_clear_self: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !clr_evt);

  a_r9_no_relatch: assert property (@(posedge clk) disable iff (!rst_n)
    (out_hiz && !fault_lat && !clr_evt && !pass_evt) |=> !fault_lat);

  a_r9_trip_only_play: assert property (@(posedge clk) disable iff (!rst_n)
    (out_hiz && oc_trip) |-> !trip_evt);
endmodule

bind ocp_fault_mgr ocp_fault_mgr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .oc_trip(oc_trip),
  .diag_req(diag_req), .out_hiz(out_hiz), .fault_n(fault_n),
  .ilim_sel(ilim_sel), .trip_evt(trip_evt), .clr_evt(clr_evt),
  .pass_evt(pass_evt), .fail_evt(fail_evt), .fault_lat(fault_lat)
);

// File: tb/ocp_fault_mgr_tb.sv
`timescale 1ns/1ps
module ocp_fault_mgr_tb;
  localparam int TICKS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic oc_trip = 1'b0, tick_1s = 1'b0, diag_done = 1'b0, diag_pass = 1'b0;
  logic diag_req, out_hiz, fault_n, ilim_sel;

  int checks = 0;
  int errors = 0;
  int req_cnt = 0;
  int cyc = 0;
  logic [7:0] rd;

  always #2 clk = ~clk;

  ocp_fault_mgr #(.RETRY_TICKS(TICKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .oc_trip(oc_trip),
    .tick_1s(tick_1s), .diag_req(diag_req), .diag_done(diag_done),
    .diag_pass(diag_pass), .out_hiz(out_hiz), .fault_n(fault_n),
    .ilim_sel(ilim_sel)
  );

  always @(posedge clk) begin
    if (rst_n && diag_req) req_cnt <= req_cnt + 1;
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d expected<=20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic clear_cmd();
    wr_reg(8'h21, 8'h80);
    @(negedge clk);
  endtask

  task automatic trip_pulse();
    @(negedge clk); oc_trip = 1'b1;
    @(negedge clk); oc_trip = 1'b0;
  endtask

  task automatic tick_pulse();
    @(negedge clk); tick_1s = 1'b1;
    @(negedge clk); tick_1s = 1'b0;
  endtask

  task automatic done_pulse(input logic pass);
    @(negedge clk); diag_done = 1'b1; diag_pass = pass;
    @(negedge clk); diag_done = 1'b0; diag_pass = 1'b0;
  endtask

  typedef struct packed {
    logic [7:0] wd;
    logic       sel;
    logic [7:0] rb;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{wd: 8'h10, sel: 1'b1, rb: 8'h10},
    '{wd: 8'h01, sel: 1'b0, rb: 8'h01},
    '{wd: 8'h11, sel: 1'b1, rb: 8'h11},
    '{wd: 8'hFF, sel: 1'b1, rb: 8'h11},
    '{wd: 8'h00, sel: 1'b0, rb: 8'h00}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 out_hiz", out_hiz, 0);
    chk("R10 fault_n", fault_n, 1);
    chk("R10 ilim_sel", ilim_sel, 0);
    rd_reg(8'h01, rd); chk("R10 cfg", rd, 0);
    rd_reg(8'h10, rd); chk("R10 status", rd, 0);

    // R7 table of configuration writes
    for (int i = 0; i < 5; i++) begin
      wr_reg(8'h01, VECS[i].wd);
      chk("R7 ilim_sel", ilim_sel, VECS[i].sel);
      rd_reg(8'h01, rd); chk("R7 cfg readback", rd, VECS[i].rb);
    end

    // R3 clear while playing has no effect
    clear_cmd();
    chk("R3 clear in play hiz", out_hiz, 0);
    chk("R3 clear in play fault_n", fault_n, 1);

    // Diagnostics disabled path
    trip_pulse();
    chk("R1 trip hiz", out_hiz, 1);
    chk("R2 fault_n low", fault_n, 0);
    rd_reg(8'h10, rd); chk("R2 latched bit", rd, 1);
    repeat (5) @(negedge clk);
    chk("R3 still hiz", out_hiz, 1);
    rd_reg(8'h10, rd); chk("R3 still latched", rd, 1);
    wr_reg(8'h21, 8'h80);
    rd_reg(8'h21, rd); chk("R8 clear reads zero", rd, 0);
    chk("R6 hold hiz", out_hiz, 1);
    chk("R6 no request", req_cnt, 0);
    rd_reg(8'h10, rd); chk("R3 bit cleared by clear", rd, 0);
    @(negedge clk); oc_trip = 1'b1;
    repeat (2) @(negedge clk);
    rd_reg(8'h10, rd); chk("R9 trip in hold ignored", rd, 0);
    clear_cmd();
    @(negedge clk);
    chk("R6 clear with trip high stays hiz", out_hiz, 1);
    oc_trip = 1'b0;
    clear_cmd();
    chk("R6 second clear to play", out_hiz, 0);
    chk("R6 fault_n released", fault_n, 1);

    // Diagnostics enabled path
    wr_reg(8'h01, 8'h01);
    trip_pulse();
    chk("R1 trip hiz again", out_hiz, 1);
    clear_cmd();
    @(negedge clk);
    chk("R4 one request", req_cnt, 1);
    chk("R4 hiz during diag", out_hiz, 1);
    done_pulse(1'b0);
    chk("R5 fail keeps hiz", out_hiz, 1);
    chk("R5 fail keeps fault_n", fault_n, 0);
    for (int t = 0; t < TICKS - 1; t++) tick_pulse();
    @(negedge clk);
    chk("R5 no early request", req_cnt, 1);
    tick_pulse();
    @(negedge clk);
    chk("R5 retry request", req_cnt, 2);
    chk("R5 hiz during retry", out_hiz, 1);
    @(negedge clk); oc_trip = 1'b1;
    repeat (2) @(negedge clk);
    rd_reg(8'h10, rd); chk("R9 trip in diag ignored", rd, 0);
    chk("R9 no extra request", req_cnt, 2);
    oc_trip = 1'b0;
    done_pulse(1'b1);
    chk("R4 pass to play", out_hiz, 0);
    chk("R4 fault_n released", fault_n, 1);
    repeat (3) @(negedge clk);
    chk("R4 single request per attempt", req_cnt, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule